// File: doc/BRIEF.md
# SPI-master bus byte bridge

This block links a host that has only an SPI slave port to a shared asynchronous NRZ serial bus. A frame on the bus is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts `BIT_CLKS` clock cycles. The bridge is always the SPI master and the host is always the slave. The bridge drives SCK at the bus bit rate. SCK idles low. Data changes on the rising (leading) edge and is sampled on the falling (trailing) edge. SPI bytes travel most significant bit first.

Bytes heard on the bus are sampled at mid-bit and then shifted to the host. To send a byte, the host pulls its request line low. The bridge then clocks the byte in over SPI and transmits it as a full frame. One active-low flag, `ctrl_o`, tells the host that a byte is in progress. If another node starts a frame before the host's request is accepted, the request is dropped. A frame with a bad stop bit silences the host side until end-of-message is signalled.

The controller has five states:
- `ST_IDLE`: waits for a received byte, a framing error, or an accepted request.
- `ST_HOST_IN`: eight SCK periods, clocking in the host byte.
- `ST_BUS_OUT`: ten bit times on `bus_tx`.
- `ST_HOST_OUT`: eight SCK periods, shifting the received byte to the host.
- `ST_HALT`: entered after a framing error; left on `eom_i`.

The transitions are:
- `ST_IDLE` to `ST_HALT` on a framing error.
- `ST_IDLE` to `ST_HOST_OUT` on a good frame.
- `ST_IDLE` to `ST_HOST_IN` on an accepted request while no reception is under way.
- `ST_HOST_IN` to `ST_BUS_OUT` after the eighth bit.
- `ST_BUS_OUT` to `ST_IDLE` after the stop bit.
- `ST_HOST_OUT` to `ST_IDLE` after the eighth bit.
- `ST_HALT` to `ST_IDLE` on `eom_i`.
- Any state to `ST_IDLE` whenever the block is deselected.

Top module: `spi_bus_bridge`

## Requirements
- R1: After reset, `sck_o` is 0, `bus_tx` is 1 and `ctrl_o` is 1.
- R2: The block acts only while `mode_sel`=1 and `cs_n`=0. When deselected, bus frames produce no SCK, requests produce no bus frame, and `ctrl_o` stays 1.
- R3: After a falling edge on `bus_rx`, the start bit is re-checked BIT_CLKS/2 cycles later. A low pulse shorter than that is discarded and delivers nothing to the host.
- R4: A good received byte is delivered to the host on `host_dout` MSB first, using eight SCK pulses one bit time apart. Each pulse is high for BIT_CLKS/2 cycles, and `host_dout` changes only on SCK rising edges.
- R5: `ctrl_o` is 0 while a byte is being received, shifted to or from the host, or transmitted. It is 1 once the bridge is idle again.
- R6: A request is accepted only after `ctrl_req_n` has been low for REQ_MIN synchronized cycles. A shorter low pulse causes no SCK and no bus frame.
- R7: After an accepted request, the bridge gives eight SCK pulses and samples `host_din` on each falling edge, MSB first.
- R8: The host byte is sent on `bus_tx` as a 0 start bit, then the eight data bits LSB first, then a 1 stop bit, each lasting BIT_CLKS cycles. `bus_tx` is 1 when not transmitting.
- R9: Reception has priority over a request. If a bus start edge is seen before the request is accepted, the request is dropped: the received byte is delivered and no frame is sent.
- R10: A received frame whose stop bit is 0 stops all SCK generation. Frames that arrive afterwards are discarded until `eom_i` is 1, after which reception resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; one bit lasts BIT_CLKS cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Mode strap; must be 1 for the block to act |
| cs_n | input | 1 | Active-low select; must be 0 for the block to act |
| eom_i | input | 1 | End-of-message indication; releases the halt state |
| bus_rx | input | 1 | Receive level of the serial bus, idle high |
| bus_tx | output | 1 | Transmit level onto the serial bus, idle high |
| sck_o | output | 1 | SPI shift clock to the host, idle low |
| host_dout | output | 1 | Serial data to the host |
| host_din | input | 1 | Serial data from the host |
| ctrl_req_n | input | 1 | Host transmit request, active low, asynchronous |
| ctrl_o | output | 1 | Active-low flag: a byte is in progress |

## Verification
A host transmit request and the start of a frame from another node can arrive together. The bench provokes this by pulling `ctrl_req_n` low and driving a start bit on `bus_rx` on the same clock edge, and holding the request well past REQ_MIN. The result is judged at the ports. The received byte must reach the host intact over eight SCK pulses. `bus_tx` must show no falling edge, either during that frame or for several bit times after it.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOST_IN,
        ST_BUS_OUT,
        ST_HOST_OUT,
        ST_HALT
    } bb_state_t;

    localparam int BYTE_BITS  = 8;
    localparam int FRAME_BITS = 10;
endpackage

// File: rtl/bb_req_filter.sv
module bb_req_filter #(
    parameter int REQ_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req_n_i,
    output logic req_pulse
);
    localparam int CW = $clog2(REQ_MIN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] low_cnt;

    // Two-stage synchronizer, then a saturating count of consecutive low cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= 2'b11;
            low_cnt   <= '0;
            req_pulse <= 1'b0;
        end else begin
            sync_q    <= {sync_q[0], req_n_i};
            req_pulse <= 1'b0;
            if (!en || sync_q[1]) begin
                low_cnt <= '0;
            end else if (low_cnt < CW'(REQ_MIN)) begin
                low_cnt <= low_cnt + 1'b1;
                if (low_cnt == CW'(REQ_MIN - 1)) begin
                    req_pulse <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bb_rx_frame.sv
module bb_rx_frame #(
    parameter int BIT_CLKS = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       line_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       ferr_o,
    output logic [7:0] data_o
);
    localparam int CW   = $clog2(BIT_CLKS);
    localparam int HALF = BIT_CLKS / 2;

    logic [1:0]    sync_q;
    logic          line_s;
    logic [CW-1:0] cnt;
    logic [3:0]    idx;   // 0 = start, 1..8 = data, 9 = stop
    logic [7:0]    shreg;
    logic [CW-1:0] target;

    assign line_s = sync_q[1];
    assign target = (idx == 4'd0) ? CW'(HALF - 1) : CW'(BIT_CLKS - 1);
    assign data_o = shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            ferr_o <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            done_o <= 1'b0;
            ferr_o <= 1'b0;
            if (!en) begin
                busy_o <= 1'b0;
            end else if (!busy_o) begin
                if (!line_s) begin
                    busy_o <= 1'b1;
                    cnt    <= '0;
                    idx    <= '0;
                end
            end else if (cnt == target) begin
                cnt <= '0;
                if (idx == 4'd0) begin
                    if (line_s) busy_o <= 1'b0;   // start bit did not hold
                    else        idx    <= 4'd1;
                end else if (idx <= 4'd8) begin
                    shreg <= {line_s, shreg[7:1]};
                    idx   <= idx + 4'd1;
                end else begin
                    busy_o <= 1'b0;
                    if (line_s) done_o <= 1'b1;
                    else        ferr_o <= 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_bus_bridge.sv
module spi_bus_bridge #(
    parameter int BIT_CLKS = 128,
    parameter int REQ_MIN  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic cs_n,
    input  logic eom_i,
    input  logic bus_rx,
    output logic bus_tx,
    output logic sck_o,
    output logic host_dout,
    input  logic host_din,
    input  logic ctrl_req_n,
    output logic ctrl_o
);
    import bb_pkg::*;

    localparam int PW   = $clog2(BIT_CLKS);
    localparam int HALF = BIT_CLKS / 2;

    bb_state_t  st, nxt;
    logic       en, rx_en;
    logic       rx_busy, rx_done, rx_ferr, req_pulse;
    logic [7:0] rx_data;
    logic [7:0] shreg;
    logic [PW-1:0] ph_q;
    logic [3:0]    bit_q;
    logic          ph_end;
    logic [3:0]    bm1;
    logic [2:0]    ridx;

    assign en     = mode_sel & ~cs_n;
    assign rx_en  = en && (st == ST_IDLE || st == ST_HOST_OUT);
    assign ph_end = (ph_q == PW'(BIT_CLKS - 1));
    assign bm1    = bit_q - 4'd1;
    assign ridx   = 3'd7 - bit_q[2:0];

    bb_req_filter #(.REQ_MIN(REQ_MIN)) u_req (
        .clk(clk), .rst_n(rst_n), .en(en),
        .req_n_i(ctrl_req_n), .req_pulse(req_pulse)
    );

    bb_rx_frame #(.BIT_CLKS(BIT_CLKS)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .line_i(bus_rx),
        .busy_o(rx_busy), .done_o(rx_done), .ferr_o(rx_ferr), .data_o(rx_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (rx_ferr)                   nxt = ST_HALT;
                else if (rx_done)              nxt = ST_HOST_OUT;
                else if (req_pulse && !rx_busy) nxt = ST_HOST_IN;
            end
            ST_HOST_IN:  if (ph_end && bit_q == 4'(BYTE_BITS - 1))  nxt = ST_BUS_OUT;
            ST_BUS_OUT:  if (ph_end && bit_q == 4'(FRAME_BITS - 1)) nxt = ST_IDLE;
            ST_HOST_OUT: if (ph_end && bit_q == 4'(BYTE_BITS - 1))  nxt = ST_IDLE;
            ST_HALT:     if (eom_i) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    // Bit-time counters and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= '0;
            bit_q <= '0;
            shreg <= '0;
        end else if (st != nxt) begin
            ph_q  <= '0;
            bit_q <= '0;
            if (nxt == ST_HOST_OUT) shreg <= rx_data;
        end else if (st == ST_HOST_IN || st == ST_BUS_OUT || st == ST_HOST_OUT) begin
            if (ph_end) begin
                ph_q  <= '0;
                bit_q <= bit_q + 4'd1;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
            if (st == ST_HOST_IN && ph_q == PW'(HALF)) begin
                shreg <= {shreg[6:0], host_din};
            end
        end
    end

    // Outputs
    always_comb begin
        sck_o     = 1'b0;
        host_dout = 1'b1;
        bus_tx    = 1'b1;
        ctrl_o    = 1'b1;
        unique case (st)
            ST_IDLE:    ctrl_o = !(rx_busy || rx_done);
            ST_HOST_IN: begin
                sck_o  = (ph_q < PW'(HALF));
                ctrl_o = 1'b0;
            end
            ST_BUS_OUT: begin
                ctrl_o = 1'b0;
                if (bit_q == 4'd0)      bus_tx = 1'b0;
                else if (bit_q >= 4'd9) bus_tx = 1'b1;
                else                    bus_tx = shreg[bm1[2:0]];
            end
            ST_HOST_OUT: begin
                sck_o     = (ph_q < PW'(HALF));
                ctrl_o    = 1'b0;
                host_dout = shreg[ridx];
            end
            ST_HALT: ctrl_o = 1'b1;
            default: ctrl_o = 1'b1;
        endcase
        if (!en) begin
            sck_o  = 1'b0;
            bus_tx = 1'b1;
            ctrl_o = 1'b1;
        end
    end
endmodule

// File: rtl/bb_checker.sv
module bb_checker (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input bb_pkg::bb_state_t st,
    input logic             rx_busy,
    input logic             sck_o,
    input logic             host_dout,
    input logic             bus_tx,
    input logic             ctrl_o
);
    import bb_pkg::*;

    a_r2_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == ST_IDLE));

    a_r4_data_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOST_OUT && $past(st) == ST_HOST_OUT && !$rose(sck_o)) |-> $stable(host_dout));

    a_r5_sck_flags_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !ctrl_o);

    a_r5_tx_flags_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_tx |-> !ctrl_o);

    a_r8_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> bus_tx);

    a_r9_rx_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && rx_busy) |=> (st != ST_HOST_IN));

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT) |-> (!sck_o && bus_tx));
endmodule

bind spi_bus_bridge bb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .st(st), .rx_busy(rx_busy),
    .sck_o(sck_o), .host_dout(host_dout), .bus_tx(bus_tx), .ctrl_o(ctrl_o)
);

// File: tb/spi_bus_bridge_bench.sv
`timescale 1ns/1ps
module spi_bus_bridge_bench;
    localparam int BIT  = 128;
    localparam int REQ  = 16;
    localparam int NVEC = 4;
    // each entry: {byte sent by a remote node, byte sent by the host}
    localparam logic [15:0] VEC [NVEC] = '{16'hA5_3C, 16'h01_80, 16'hFE_7F, 16'h5A_C3};

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_sel = 1'b1, cs_n = 1'b0, eom_i = 1'b0;
    logic bus_rx = 1'b1, host_din = 1'b0, ctrl_req_n = 1'b1;
    logic bus_tx, sck_o, host_dout, ctrl_o;

    int compared = 0, mismatched = 0;
    int sck_rises = 0, tx_falls = 0;

    always #5 clk = ~clk;

    spi_bus_bridge #(.BIT_CLKS(BIT), .REQ_MIN(REQ)) u_spi_bus_bridge (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .eom_i(eom_i),
        .bus_rx(bus_rx), .bus_tx(bus_tx), .sck_o(sck_o), .host_dout(host_dout),
        .host_din(host_din), .ctrl_req_n(ctrl_req_n), .ctrl_o(ctrl_o)
    );

    always @(posedge sck_o) sck_rises++;
    always @(negedge bus_tx) tx_falls++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_v);
        bus_rx = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            bus_rx = b[i];
            repeat (BIT) @(negedge clk);
        end
        bus_rx = stop_v;
        repeat (BIT) @(negedge clk);
        bus_rx = 1'b1;
    endtask

    task automatic host_capture(output logic [7:0] got, output int hi, output int ctrl_bad);
        got = '0; hi = 0; ctrl_bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge sck_o);
            @(negedge clk);
            got[7-i] = host_dout;
            if (ctrl_o) ctrl_bad++;
            if (i == 0) begin
                while (sck_o) begin hi++; @(negedge clk); end
            end
        end
    endtask

    task automatic host_slave(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(posedge sck_o);
            host_din = b[7-i];
        end
    endtask

    task automatic bus_capture(output logic [7:0] got, output logic st_ok,
                               output logic sp_ok, output logic ctl);
        @(negedge bus_tx);
        repeat (BIT/2) @(negedge clk);
        st_ok = !bus_tx;
        ctl   = ctrl_o;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            got[i] = bus_tx;
        end
        repeat (BIT) @(negedge clk);
        sp_ok = bus_tx;
    endtask

    task automatic request(input int n);
        ctrl_req_n = 1'b0;
        repeat (n) @(negedge clk);
        ctrl_req_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] got;
        int hi, cbad, s0, t0;
        logic st_ok, sp_ok, ctl;

        repeat (3) @(negedge clk);
        check("R1 sck after reset", sck_o, 1'b0);
        check("R1 bus_tx after reset", bus_tx, 1'b1);
        check("R1 ctrl after reset", ctrl_o, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 bus_tx idle high", bus_tx, 1'b1);

        // Vector table: receive then transmit for each entry
        for (int v = 0; v < NVEC; v++) begin
            fork
                send_frame(VEC[v][15:8], 1'b1);
                host_capture(got, hi, cbad);
                begin repeat (BIT) @(negedge clk); check("R5 ctrl low while receiving", ctrl_o, 1'b0); end
            join
            check("R4 received byte at host", got, VEC[v][15:8]);
            check("R4 SCK high time", hi, BIT/2);
            check("R5 ctrl low during shift", cbad, 0);
            repeat (BIT + 4) @(negedge clk);
            check("R5 ctrl high when idle", ctrl_o, 1'b1);

            s0 = sck_rises;
            fork
                request(REQ + 4);
                host_slave(VEC[v][7:0]);
                bus_capture(got, st_ok, sp_ok, ctl);
            join
            check("R7 eight SCK pulses for host byte", sck_rises - s0, 8);
            check("R8 start bit", st_ok, 1'b1);
            check("R8 bus data LSB first", got, VEC[v][7:0]);
            check("R8 stop bit", sp_ok, 1'b1);
            check("R5 ctrl low while transmitting", ctl, 1'b0);
            repeat (2*BIT) @(negedge clk);
        end

        // R6: request too short
        s0 = sck_rises; t0 = tx_falls;
        request(REQ - 4);
        repeat (4*BIT) @(negedge clk);
        check("R6 short request gives no SCK", sck_rises - s0, 0);
        check("R6 short request gives no frame", tx_falls - t0, 0);

        // R3: glitch on the bus shorter than half a bit
        s0 = sck_rises;
        bus_rx = 1'b0;
        repeat (20) @(negedge clk);
        bus_rx = 1'b1;
        repeat (BIT) @(negedge clk);
        check("R3 glitch released ctrl", ctrl_o, 1'b1);
        repeat (2*BIT) @(negedge clk);
        check("R3 glitch delivers nothing", sck_rises - s0, 0);

        // R9: request and start edge on the same edge
        t0 = tx_falls;
        fork
            send_frame(8'h96, 1'b1);
            request(REQ + 40);
            host_capture(got, hi, cbad);
        join
        repeat (3*BIT) @(negedge clk);
        check("R9 received byte wins", got, 8'h96);
        check("R9 request dropped, no frame", tx_falls - t0, 0);

        // R10: framing error halts SCK until end of message
        s0 = sck_rises;
        send_frame(8'hC3, 1'b0);
        repeat (2*BIT) @(negedge clk);
        check("R10 no SCK after framing error", sck_rises - s0, 0);
        send_frame(8'h11, 1'b1);
        repeat (2*BIT) @(negedge clk);
        check("R10 frame during halt discarded", sck_rises - s0, 0);
        eom_i = 1'b1;
        @(negedge clk);
        eom_i = 1'b0;
        repeat (4) @(negedge clk);
        fork
            send_frame(8'h77, 1'b1);
            host_capture(got, hi, cbad);
        join
        check("R10 reception resumes after eom", got, 8'h77);
        repeat (BIT + 4) @(negedge clk);

        // R2: deselected block ignores bus and host
        mode_sel = 1'b0;
        s0 = sck_rises; t0 = tx_falls;
        fork
            send_frame(8'h99, 1'b1);
            begin repeat (BIT) @(negedge clk); check("R2 ctrl high while deselected", ctrl_o, 1'b1); end
        join
        request(REQ + 4);
        repeat (4*BIT) @(negedge clk);
        check("R2 no SCK while deselected", sck_rises - s0, 0);
        check("R2 no frame while deselected", tx_falls - t0, 0);
        mode_sel = 1'b1;
        cs_n = 1'b1;
        request(REQ + 4);
        repeat (4*BIT) @(negedge clk);
        check("R2 cs_n high blocks request", tx_falls - t0, 0);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule